// File: doc/BRIEF.md
# Clock Control Register Bank

This block is the software-visible register bank of a clock control unit. A host reads and writes 32-bit words over a simple single-cycle request bus. The two low bits of the byte address are ignored, so the rest of the address selects a word. The bank holds these registers:

- a mode word
- two post-divider words
- two PLL setting words
- three clock-gating words
- one power-management word that the host can read but not write

Each writable register has its own write mask. The mode word also has one bit that every write forces to 1. One further word always reads back a fixed constant.

The frequency logic that reads these settings does not watch every register. Instead, the bank gives it a one-cycle `recompute` pulse in two cases: when a register that affects clock frequencies is written, and once when reset is released. Writes to the gating words change no frequency, so they raise no pulse.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset the words read as follows: word 0 = 0x074B0B7B, word 1 = 0xFF870B48, word 2 = 0x49FCFE7F, word 4 = 0x04001800, word 6 = 0x04043001, words 8, 9 and 10 = 0xFFFFFFFF, word 23 = 0x80209828.
- R2: A read request on `rdEn` makes `rdValid` high for exactly the next cycle, with the word's data on `rdata` in that cycle. `rdValid` is low in every other cycle. Address bits [1:0] do not affect which word is selected.
- R3: A write to word 0 stores `wdata & 0x3B6FDFFF` with bit 26 set to 1.
- R4: A write to word 1 stores `wdata & 0xFF9F3FFF`. A write to word 2 stores the full `wdata`.
- R5: Writes to word 4 and to word 6 store `wdata & 0xBFFF3FFF`.
- R6: Writes to words 8, 9 and 10 store the full `wdata`, each word independently of the others.
- R7: Word 18 always reads 0x00004040. Writes to word 18 and to word 23 change nothing that can be read.
- R8: A read of any unlisted word returns 0. A write to any unlisted word changes no register.
- R9: A write to word 0, 1, 2, 4 or 6 makes `recompute` high in the following cycle. Writes to other words, including the gating words 8 to 10, never raise it.
- R10: `recompute` is high for exactly the first cycle after reset is released, even when no write occurs.
- R11: When a read and a write hit the same word in the same cycle, the read returns the value the word held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write request for the current cycle |
| rdEn | input | 1 | Read request for the current cycle |
| addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rdValid is high |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| recompute | output | 1 | One-cycle pulse asking for clock settings to be recomputed |

## Verification
The hardest cases to reach are those where a write leaves no trace in the read data. These are writes to the constant word, to the read-only power word and to unmapped words, and writes to the gating words, which must raise no pulse. The stimulus follows each of these writes with a read sweep over every mapped word, so any hidden corruption shows up at the port.

The bench also models `recompute` cycle by cycle, starting from the reset release. It therefore catches a missing boot pulse and any pulse caused by a gating write. Finally, a read and a write are issued to the same word in one cycle, to fix the read-before-write ordering.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int DATA_W    = 32;
  localparam int NUM_GATES = 3;
  localparam int GATE_IDX_W = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1;

  // word offsets (host-visible map)
  localparam int OFS_MODE  = 0;
  localparam int OFS_DIV0  = 1;
  localparam int OFS_DIV1  = 2;
  localparam int OFS_PLLA  = 4;
  localparam int OFS_PLLB  = 6;
  localparam int OFS_GATE0 = 8;
  localparam int OFS_CONST = 18;
  localparam int OFS_PWR   = 23;

  // write masks and forced bits
  localparam logic [DATA_W-1:0] MODE_MASK  = 32'h3B6F_DFFF;
  localparam int                MODE_FORCE_BIT = 26;
  localparam logic [DATA_W-1:0] MODE_FORCE = DATA_W'(1) << MODE_FORCE_BIT;
  localparam logic [DATA_W-1:0] DIV0_MASK  = 32'hFF9F_3FFF;
  localparam logic [DATA_W-1:0] PLL_MASK   = 32'hBFFF_3FFF;

  // fixed read values
  localparam logic [DATA_W-1:0] PWR_VALUE   = 32'h8020_9828;
  localparam logic [DATA_W-1:0] CONST_VALUE = 32'h0000_4040;

  // PLL setting layout: prediv [29:26], denom [25:16], integer [13:10], numer [9:0]
  function automatic logic [DATA_W-1:0] pllWord(input logic [3:0] prediv,
                                                 input logic [9:0] denom,
                                                 input logic [3:0] intPart,
                                                 input logic [9:0] numer);
    return {2'b00, prediv, denom, 2'b00, intPart, numer};
  endfunction

  localparam logic [DATA_W-1:0] MODE_RST = 32'h074B_0B7B;
  localparam logic [DATA_W-1:0] DIV0_RST = 32'hFF87_0B48;
  localparam logic [DATA_W-1:0] DIV1_RST = 32'h49FC_FE7F;
  localparam logic [DATA_W-1:0] PLLA_RST = pllWord(4'd1, 10'd0, 4'd6, 10'd0);
  localparam logic [DATA_W-1:0] PLLB_RST = pllWord(4'd1, 10'd4, 4'd12, 10'd1);
  localparam logic [DATA_W-1:0] GATE_RST = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MODE, SEL_DIV0, SEL_DIV1, SEL_PLLA, SEL_PLLB, SEL_GATE, SEL_FIXED
  } rdSel_e;

  typedef struct packed {
    logic                  wrMode;
    logic                  wrDiv0;
    logic                  wrDiv1;
    logic                  wrPllA;
    logic                  wrPllB;
    logic [NUM_GATES-1:0]  wrGate;
    logic                  rdGo;
    rdSel_e                rdSel;
    logic [GATE_IDX_W-1:0] gateSel;
    logic [DATA_W-1:0]     fixedVal;
  } strobes_t;

endpackage

// File: rtl/clkctl_ctrl.sv
module clkctl_ctrl
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobes_t          strb,
  output logic              recompute
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              unusedLowBits;
  logic              clockWrite;
  logic              bootPending;

  assign word          = addr[ADDR_W-1:2];
  assign unusedLowBits = ^addr[1:0];

  // write strobes
  always_comb begin
    strb.wrMode = wrEn && (word == WORD_W'(OFS_MODE));
    strb.wrDiv0 = wrEn && (word == WORD_W'(OFS_DIV0));
    strb.wrDiv1 = wrEn && (word == WORD_W'(OFS_DIV1));
    strb.wrPllA = wrEn && (word == WORD_W'(OFS_PLLA));
    strb.wrPllB = wrEn && (word == WORD_W'(OFS_PLLB));
  end

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gateWr
    assign strb.wrGate[g] = wrEn && (word == WORD_W'(OFS_GATE0 + g));
  end

  // read select
  always_comb begin
    strb.rdGo     = rdEn;
    strb.rdSel    = SEL_NONE;
    strb.gateSel  = '0;
    strb.fixedVal = '0;
    if (word == WORD_W'(OFS_MODE))      strb.rdSel = SEL_MODE;
    else if (word == WORD_W'(OFS_DIV0)) strb.rdSel = SEL_DIV0;
    else if (word == WORD_W'(OFS_DIV1)) strb.rdSel = SEL_DIV1;
    else if (word == WORD_W'(OFS_PLLA)) strb.rdSel = SEL_PLLA;
    else if (word == WORD_W'(OFS_PLLB)) strb.rdSel = SEL_PLLB;
    else if (word == WORD_W'(OFS_CONST)) begin
      strb.rdSel    = SEL_FIXED;
      strb.fixedVal = CONST_VALUE;
    end else if (word == WORD_W'(OFS_PWR)) begin
      strb.rdSel    = SEL_FIXED;
      strb.fixedVal = PWR_VALUE;
    end
    for (int g = 0; g < NUM_GATES; g++) begin
      if (word == WORD_W'(OFS_GATE0 + g)) begin
        strb.rdSel   = SEL_GATE;
        strb.gateSel = GATE_IDX_W'(g);
      end
    end
  end

  assign clockWrite = strb.wrMode | strb.wrDiv0 | strb.wrDiv1 | strb.wrPllA | strb.wrPllB;

  // recompute pulse: once after reset, then after every clock-affecting write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bootPending <= 1'b1;
      recompute   <= 1'b0;
    end else begin
      bootPending <= 1'b0;
      recompute   <= bootPending | clockWrite;
    end
  end

endmodule

// File: rtl/clkctl_dpath.sv
module clkctl_dpath
  import clkctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdValid
);

  logic [DATA_W-1:0] modeQ, div0Q, div1Q, pllAQ, pllBQ;
  logic [DATA_W-1:0] gateQ [NUM_GATES];
  logic [DATA_W-1:0] readMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_RST;
    else if (strb.wrMode) modeQ <= (wdata & MODE_MASK) | MODE_FORCE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) div0Q <= DIV0_RST;
    else if (strb.wrDiv0) div0Q <= wdata & DIV0_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) div1Q <= DIV1_RST;
    else if (strb.wrDiv1) div1Q <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pllAQ <= PLLA_RST;
    else if (strb.wrPllA) pllAQ <= wdata & PLL_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pllBQ <= PLLB_RST;
    else if (strb.wrPllB) pllBQ <= wdata & PLL_MASK;
  end

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) gateQ[g] <= GATE_RST;
      else if (strb.wrGate[g]) gateQ[g] <= wdata;
    end
  end

  always_comb begin
    readMux = '0;
    unique case (strb.rdSel)
      SEL_MODE:  readMux = modeQ;
      SEL_DIV0:  readMux = div0Q;
      SEL_DIV1:  readMux = div1Q;
      SEL_PLLA:  readMux = pllAQ;
      SEL_PLLB:  readMux = pllBQ;
      SEL_FIXED: readMux = strb.fixedVal;
      SEL_GATE: begin
        for (int g = 0; g < NUM_GATES; g++) begin
          if (strb.gateSel == GATE_IDX_W'(g)) readMux = gateQ[g];
        end
      end
      default:   readMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata   <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdGo;
      if (strb.rdGo) rdata <= readMux;
    end
  end

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rdValid,
  output logic              recompute
);

  strobes_t strb;

  clkctl_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .addr      (addr),
    .strb      (strb),
    .recompute (recompute)
  );

  clkctl_dpath u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wdata   (wdata),
    .rdata   (rdata),
    .rdValid (rdValid)
  );

endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic              rdValid,
  input logic              recompute
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic clkWord, mappedWord, unusedLow;
  logic seen1, seen2;

  assign word      = addr[ADDR_W-1:2];
  assign unusedLow = ^addr[1:0];
  assign clkWord   = (word == WORD_W'(0)) || (word == WORD_W'(1)) || (word == WORD_W'(2)) ||
                     (word == WORD_W'(4)) || (word == WORD_W'(6));
  assign mappedWord = clkWord || (word == WORD_W'(8)) || (word == WORD_W'(9)) ||
                      (word == WORD_W'(10)) || (word == WORD_W'(18)) || (word == WORD_W'(23));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen1 <= 1'b0;
      seen2 <= 1'b0;
    end else begin
      seen1 <= 1'b1;
      seen2 <= seen1;
    end
  end

  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN) rdEn |=> rdValid);
  // R2
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rstN) !rdEn |=> !rdValid);
  // R3
  mode_forced_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(rdEn && word == WORD_W'(0))) |-> rdata[26]);
  // R7
  const_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(rdEn && word == WORD_W'(18))) |-> rdata == 32'h0000_4040);
  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(rdEn && !mappedWord)) |-> rdata == 32'h0);
  // R9
  recompute_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && clkWord) |=> recompute);
  // R9
  recompute_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seen2 && recompute) |-> $past(wrEn && clkWord));
  // R10
  boot_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seen1 && !seen2) |-> recompute);

endmodule

bind clkctl_regbank clkctl_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .addr      (addr),
  .rdata     (rdata),
  .rdValid   (rdValid),
  .recompute (recompute)
);

// File: tb/tb_clkctl_regbank.sv
`timescale 1ns/1ps
module tb_clkctl_regbank;

  localparam int ADDR_W = 12;
  localparam int HALF   = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              rdValid;
  logic              recompute;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  logic expRec, bootModel;

  always #HALF clk = ~clk;

  clkctl_regbank #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdValid(rdValid), .recompute(recompute)
  );

  function automatic bit clkAffecting(input logic [ADDR_W-1:0] a);
    int w = int'(a >> 2);
    return (w == 0) || (w == 1) || (w == 2) || (w == 4) || (w == 6);
  endfunction

  // R9 / R10 reference for the recompute pulse
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expRec    <= 1'b0;
      bootModel <= 1'b1;
    end else begin
      expRec    <= bootModel || (wrEn && clkAffecting(addr));
      bootModel <= 1'b0;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (recompute !== expRec) begin
        fails++;
        $display("FAIL R9/R10 recompute actual=%0b expected=%0b at %0t", recompute, expRec, $time);
      end
      if (rdValid) begin
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R2 unexpected rdValid actual=1 expected=0");
        end else begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (rdata !== e) begin
            fails++;
            $display("FAIL %s rdata actual=%08h expected=%08h", t, rdata, e);
          end
        end
      end
    end
  end

  task automatic busCycle(input logic w, input logic r, input int byteAddr,
                          input logic [31:0] d, input logic [31:0] e, input string tag);
    @(posedge clk);
    #2;
    wrEn  = w;
    rdEn  = r;
    addr  = ADDR_W'(byteAddr);
    wdata = d;
    if (r) begin
      expQ.push_back(e);
      tagQ.push_back(tag);
    end
  endtask

  task automatic doWrite(input int wordOfs, input logic [31:0] d);
    busCycle(1'b1, 1'b0, wordOfs * 4, d, '0, "");
  endtask

  task automatic doRead(input int wordOfs, input logic [31:0] e, input string tag);
    busCycle(1'b0, 1'b1, wordOfs * 4, '0, e, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) busCycle(1'b0, 1'b0, 0, '0, '0, "");
  endtask

  // current expected contents of the mapped words
  logic [31:0] mdl [0:23];

  task automatic sweep(input string tag);
    foreach (mdl[i]) doRead(i, mdl[i], tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 2 * HALF);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    foreach (mdl[i]) mdl[i] = 32'h0;
    mdl[0] = 32'h074B0B7B; mdl[1] = 32'hFF870B48; mdl[2] = 32'h49FCFE7F;
    mdl[4] = 32'h04001800; mdl[6] = 32'h04043001;
    mdl[8] = 32'hFFFFFFFF; mdl[9] = 32'hFFFFFFFF; mdl[10] = 32'hFFFFFFFF;
    mdl[18] = 32'h00004040; mdl[23] = 32'h80209828;

    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    idle(3);                              // R10 boot pulse checked by monitor

    sweep("R1");                           // reset values, R7 const, R8 unmapped zero
    doRead(64, 32'h0, "R8");               // far unmapped word
    busCycle(1'b0, 1'b1, 5, '0, mdl[1], "R2");   // low address bits ignored
    busCycle(1'b0, 1'b1, 11, '0, mdl[2], "R2");

    doWrite(0, 32'hFFFFFFFF); mdl[0] = 32'h3F6FDFFF;
    doRead(0, mdl[0], "R3");
    doWrite(0, 32'h0); mdl[0] = 32'h04000000;
    doRead(0, mdl[0], "R3");

    doWrite(1, 32'hFFFFFFFF); mdl[1] = 32'hFF9F3FFF;
    doWrite(2, 32'h12345678); mdl[2] = 32'h12345678;   // back-to-back R9 pulses
    doRead(1, mdl[1], "R4");
    doRead(2, mdl[2], "R4");

    doWrite(4, 32'hFFFFFFFF); mdl[4] = 32'hBFFF3FFF;
    doWrite(6, 32'h5555AAAA); mdl[6] = 32'h15552AAA;
    idle(2);
    doRead(4, mdl[4], "R5");
    doRead(6, mdl[6], "R5");

    doWrite(8, 32'hA5A5A5A5); mdl[8] = 32'hA5A5A5A5;  // R9: no pulse on gating writes
    idle(1);
    doWrite(9, 32'h00000000); mdl[9] = 32'h00000000;
    idle(1);
    doWrite(10, 32'h13579BDF); mdl[10] = 32'h13579BDF;
    idle(2);
    sweep("R6");

    doWrite(18, 32'hDEADBEEF);
    doWrite(23, 32'h00000000);
    for (int w = 0; w < 32; w++) begin
      if (!(w inside {0, 1, 2, 4, 6, 8, 9, 10, 18, 23})) doWrite(w, 32'hCAFEF00D);
    end
    doWrite(100, 32'hCAFEF00D);
    idle(2);
    sweep("R7/R8 after ignored writes");
    doRead(18, 32'h00004040, "R7");
    doRead(23, 32'h80209828, "R7");

    busCycle(1'b1, 1'b1, 2 * 4, 32'h0BADCAFE, mdl[2], "R11");
    mdl[2] = 32'h0BADCAFE;
    doRead(2, mdl[2], "R11");
    busCycle(1'b1, 1'b1, 9 * 4, 32'h77777777, mdl[9], "R11");
    mdl[9] = 32'h77777777;
    doRead(9, mdl[9], "R11");

    idle(4);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R2 missing read results actual=%0d expected=0", expQ.size());
    end
    finishRun();
  end

endmodule